// File: doc/BRIEF.md
# Stereo Serial Audio Slot Transmitter

This block turns pairs of parallel PCM samples into a three-wire stereo serial audio stream in the I2S format: a bit clock, a channel-select line and a serial data line. Each channel has its own holding register, loaded through a valid/ready handshake. At the start of each channel slot the held sample is moved into a shift register. The bit clock is derived inside the block from a tick input. Each pulse of the tick toggles the bit clock, so the bit rate is set by how often the tick fires.

Every sample fills a 32-bit slot and is sent most significant bit first. The first bit follows the channel-select change by one bit period. Samples are 24 or 16 bits wide. The low bits of the slot that the sample does not cover are filled either with zeros or with copies of the sample's sign bit. A receiver that reads only the sample bits gets the same audio in both fill modes. If a channel has no fresh sample when its slot starts, the previous sample is sent again and a sticky underrun flag is raised. The flag stays high until it is cleared.

Top module: `i2s_slot_tx`

## Requirements
- R1: While reset is asserted and right after it is released, bclk_o, ws_o and sd_o are low, underrun_o is low, and both ready outputs are high.
- R2: Each cycle with tick_i high toggles bclk_o. ws_o and sd_o change only on a falling transition of bclk_o.
- R3: ws_o is low for the left channel and high for the right channel. Each level lasts exactly 32 bit-clock periods.
- R4: The slot MSB is driven in the bit period after the ws_o change, and the slot bits follow MSB first. The slot LSB is therefore on the line during the first bit period after the next ws_o change.
- R5: With width24_i high, slot bits 31..8 carry sample bits 23..0 and slot bits 7..0 are filler. With width24_i low, slot bits 31..16 carry sample bits 15..0, slot bits 15..0 are filler, and sample bits 23..16 have no effect.
- R6: With sign_fill_i low, all filler bits are 0.
- R7: With sign_fill_i high, every filler bit equals the sample's sign bit: bit 23 in 24-bit mode, bit 15 in 16-bit mode. A negative sample therefore gives trailing ones.
- R8: A channel's ready output is high while its holding register is empty. A sample is taken in the cycle where valid and ready are both high, and ready drops in the next cycle. Ready rises again when the slot that uses the sample starts.
- R9: If a slot starts while its holding register is empty, the last sample held for that channel is sent again and underrun_o goes high. underrun_o stays high until a cycle with underrun_clr_i high and no new underrun.
- R10: After reset, sd_o stays low until the first falling transition of ws_o. The first left slot begins with the bit period after that transition, and then takes a sample already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Bit-clock toggle enable, one system clock per pulse |
| width24_i | input | 1 | 1: 24-bit samples, 0: 16-bit samples |
| sign_fill_i | input | 1 | 1: fill unused slot bits with the sign bit, 0: with zeros |
| l_data_i | input | 24 | Left sample, two's complement |
| l_valid_i | input | 1 | Left sample valid |
| l_ready_o | output | 1 | Left holding register empty |
| r_data_i | input | 24 | Right sample, two's complement |
| r_valid_i | input | 1 | Right sample valid |
| r_ready_o | output | 1 | Right holding register empty |
| underrun_clr_i | input | 1 | Clears the underrun flag |
| underrun_o | output | 1 | Sticky underrun flag |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Channel select, 0 left, 1 right |
| sd_o | output | 1 | Serial data |

## Verification
The hardest cases to reach are the slot that repeats its sample on an underrun and the first left slot after reset. Both depend on what the holding register contains at a load the port cannot see directly. The bench reaches the repeat by feeding the left channel once and then holding it back for a whole frame, and expects the same slot twice along with the raised flag. For the start-up case it loads both channels during the pre-roll, before the first falling transition of ws_o, and expects a silent right slot first. The bench decodes the line only at rising bit-clock edges, aligned to the ws_o transitions, so a one-period shift of the data shows up as a wrong word.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SLOT_W = 32;
  localparam int SMP_W  = 24;
  localparam int NAR_W  = 16;

  // sample left-justified in slot, filler below the LSB
  function automatic logic [SLOT_W-1:0] build_slot(input logic [SMP_W-1:0] s,
                                                   input logic wide,
                                                   input logic sgn);
    logic f;
    logic [SLOT_W-1:0] r;
    if (wide) begin
      f = sgn & s[SMP_W-1];
      r = {s, {(SLOT_W-SMP_W){f}}};
    end else begin
      f = sgn & s[NAR_W-1];
      r = {s[NAR_W-1:0], {(SLOT_W-NAR_W){f}}};
    end
    return r;
  endfunction
endpackage

// File: rtl/i2s_tx_timing.sv
module i2s_tx_timing #(
  parameter int SLOT_W = 32,
  localparam int IDX_W = $clog2(2*SLOT_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic bclk_o,
  output logic ws_o,
  output logic fall_o,
  output logic load_l_o,
  output logic load_r_o
);
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic             bclk_q, primed_q, primed_nx;

  assign fall_o    = tick_i & bclk_q;
  assign idx_nx    = idx_q + IDX_W'(1);
  assign primed_nx = primed_q | (idx_q == '1);

  // slot load one bit period after each ws edge
  assign load_l_o = fall_o & primed_nx & (idx_nx == IDX_W'(1));
  assign load_r_o = fall_o & primed_nx & (idx_nx == IDX_W'(SLOT_W + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q   <= 1'b0;
      idx_q    <= '0;
      primed_q <= 1'b0;
    end else if (tick_i) begin
      bclk_q <= ~bclk_q;
      if (bclk_q) begin
        idx_q    <= idx_nx;
        primed_q <= primed_nx;
      end
    end
  end

  assign bclk_o = bclk_q;
  assign ws_o   = idx_q[IDX_W-1];
endmodule

// File: rtl/i2s_tx_hold.sv
module i2s_tx_hold #(
  parameter int SMP_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] data_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic             load_i,
  output logic [SMP_W-1:0] word_o,
  output logic             miss_o
);
  logic [SMP_W-1:0] hold_q;
  logic             full_q, acc;

  assign acc = valid_i & ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (acc) hold_q <= data_i;
      if (acc)         full_q <= 1'b1;
      else if (load_i) full_q <= 1'b0;
    end
  end

  // empty at load: old value is reused
  assign miss_o  = load_i & ~full_q;
  assign ready_o = ~full_q;
  assign word_o  = hold_q;
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift #(
  parameter int SLOT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              sd_o
);
  logic [SLOT_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= slot_i;
    else if (fall_i) sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
  end

  assign sd_o = sh_q[SLOT_W-1];
endmodule

// File: rtl/i2s_slot_tx.sv
module i2s_slot_tx
  import i2s_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             width24_i,
  input  logic             sign_fill_i,
  input  logic [SMP_W-1:0] l_data_i,
  input  logic             l_valid_i,
  output logic             l_ready_o,
  input  logic [SMP_W-1:0] r_data_i,
  input  logic             r_valid_i,
  output logic             r_ready_o,
  input  logic             underrun_clr_i,
  output logic             underrun_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             sd_o
);
  localparam int NCH = 2;

  logic [NCH-1:0][SMP_W-1:0] din, word;
  logic [NCH-1:0]            vld, rdy, ld, miss;
  logic                      fall, und_q;
  logic [SLOT_W-1:0]         slot;

  assign din[0] = l_data_i;
  assign din[1] = r_data_i;
  assign vld    = {r_valid_i, l_valid_i};
  assign l_ready_o = rdy[0];
  assign r_ready_o = rdy[1];

  i2s_tx_timing #(.SLOT_W(SLOT_W)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .bclk_o   (bclk_o),
    .ws_o     (ws_o),
    .fall_o   (fall),
    .load_l_o (ld[0]),
    .load_r_o (ld[1])
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    i2s_tx_hold #(.SMP_W(SMP_W)) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .data_i  (din[c]),
      .valid_i (vld[c]),
      .ready_o (rdy[c]),
      .load_i  (ld[c]),
      .word_o  (word[c]),
      .miss_o  (miss[c])
    );
  end

  assign slot = build_slot(ld[0] ? word[0] : word[1], width24_i, sign_fill_i);

  i2s_tx_shift #(.SLOT_W(SLOT_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall),
    .load_i (|ld),
    .slot_i (slot),
    .sd_o   (sd_o)
  );

  // new miss wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             und_q <= 1'b0;
    else if (|miss)          und_q <= 1'b1;
    else if (underrun_clr_i) und_q <= 1'b0;
  end

  assign underrun_o = und_q;
endmodule

// File: rtl/i2s_slot_tx_chk.sv
module i2s_slot_tx_chk #(
  parameter int SLOT_W = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic bclk_o,
  input logic ws_o,
  input logic sd_o,
  input logic l_valid_i,
  input logic l_ready_o,
  input logic r_valid_i,
  input logic r_ready_o,
  input logic underrun_clr_i,
  input logic underrun_o
);
  logic       prev_bclk, prev_ws, fell_seen;
  logic [7:0] cnt;

  assign fell_seen = prev_bclk & ~bclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_bclk <= 1'b0;
      prev_ws   <= 1'b0;
      cnt       <= '0;
    end else begin
      prev_bclk <= bclk_o;
      prev_ws   <= ws_o;
      if (fell_seen) cnt <= (ws_o != prev_ws) ? '0 : cnt + 8'd1;
    end
  end

  p_bclk_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (bclk_o != $past(bclk_o)));
  p_bclk_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(bclk_o));
  p_ws_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(bclk_o));
  p_sd_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(bclk_o));
  p_ws_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fell_seen && ws_o != prev_ws) |-> (cnt == 8'(SLOT_W - 1)));
  p_l_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_valid_i && l_ready_o) |=> !l_ready_o);
  p_r_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_i && r_ready_o) |=> !r_ready_o);
  p_und_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !underrun_clr_i) |=> underrun_o);
endmodule

bind i2s_slot_tx i2s_slot_tx_chk u_chk (.*);

// File: tb/sim_i2s_slot_tx.sv
`timescale 1ns/1ps
module sim_i2s_slot_tx;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic        w24 = 1'b1, sgn = 1'b0;
  logic [23:0] l_data = '0, r_data = '0;
  logic        l_valid = 1'b0, r_valid = 1'b0, clr = 1'b0;
  logic        l_ready, r_ready, und, bclk, ws, sd;

  int total = 0, bad = 0;
  logic [31:0] cap_word [0:511];
  logic        cap_ch   [0:511];
  int          n_cap = 0;
  int          edge_bad = 0, ws_bad = 0;
  logic        m_bclk = 0, m_ws = 0, m_sd = 0, s_ws = 0, collecting = 0, ch_cur = 0, seen = 0;
  int          bitcnt = 0, samp_cnt = 0;
  logic [31:0] acc = '0;

  always #10 clk = ~clk;

  i2s_slot_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .width24_i(w24), .sign_fill_i(sgn),
    .l_data_i(l_data), .l_valid_i(l_valid), .l_ready_o(l_ready),
    .r_data_i(r_data), .r_valid_i(r_valid), .r_ready_o(r_ready),
    .underrun_clr_i(clr), .underrun_o(und), .bclk_o(bclk), .ws_o(ws), .sd_o(sd)
  );

  // tick every second system clock
  initial forever begin
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  end

  // line decoder, sampled at rising bit-clock edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (bclk && !m_bclk) begin
        samp_cnt++;
        if (collecting) begin
          acc = {acc[30:0], sd};
          bitcnt++;
          if (bitcnt == 32) begin
            if (n_cap < 512) begin
              cap_word[n_cap] = acc;
              cap_ch[n_cap]   = ch_cur;
              n_cap++;
            end
            collecting = 0;
          end
        end
        if (ws != s_ws) begin
          if (seen && samp_cnt != 32) ws_bad++;
          seen = 1; samp_cnt = 0;
          collecting = 1; bitcnt = 0; ch_cur = ws;
        end
        s_ws = ws;
      end
      if ((ws !== m_ws || sd !== m_sd) && !(m_bclk && !bclk)) edge_bad++;
    end
    m_bclk = bclk; m_ws = ws; m_sd = sd;
  end

  function automatic logic [31:0] exp_slot(logic [23:0] s, logic wide, logic sf);
    int n = wide ? 24 : 16;
    logic sb = s[n-1];
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[31-i] = (i < n) ? s[n-1-i] : (sf & sb);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic ch, logic [23:0] d);
    @(negedge clk);
    if (ch) begin r_data = d; r_valid = 1'b1; end
    else    begin l_data = d; l_valid = 1'b1; end
    while (!(ch ? r_ready : l_ready)) @(negedge clk);
    @(negedge clk);
    if (ch) r_valid = 1'b0; else l_valid = 1'b0;
  endtask

  task automatic wait_ready(logic ch);
    while (!(ch ? r_ready : l_ready)) @(negedge clk);
  endtask

  task automatic find_cap(logic ch, int start, output int idx);
    int i = start;
    forever begin
      wait (n_cap > i);
      if (cap_ch[i] == ch) break;
      i++;
    end
    idx = i;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 bclk", {31'd0, bclk}, 0);
    chk("R1 ws", {31'd0, ws}, 0);
    chk("R1 sd", {31'd0, sd}, 0);
    chk("R1 underrun", {31'd0, und}, 0);
    chk("R1 ready", {30'd0, r_ready, l_ready}, 32'd3);
  endtask

  // both channels held during pre-roll
  task automatic t_first_slot();
    int i;
    fork
      send(1'b0, 24'hA5C3E1);
      send(1'b1, 24'h0F1E2D);
    join
    wait (n_cap >= 3);
    chk("R10 preroll channel", {31'd0, cap_ch[0]}, 1);
    chk("R10 preroll data low", cap_word[0], 0);
    chk("R10 first left channel", {31'd0, cap_ch[1]}, 0);
    chk("R10 first left word", cap_word[1], exp_slot(24'hA5C3E1, 1'b1, 1'b0));
    chk("R4 first right word", cap_word[2], exp_slot(24'h0F1E2D, 1'b1, 1'b0));
    chk("R8 ready after load", {30'd0, r_ready, l_ready}, 32'd3);
    chk("R9 no underrun when fed", {31'd0, und}, 0);
  endtask

  task automatic t_pair(string tag, logic [23:0] a, logic [23:0] b, logic wide, logic sf);
    @(negedge clk); w24 = wide; sgn = sf;
    fork
      begin
        int nl, i;
        send(1'b0, a); wait_ready(1'b0); nl = n_cap;
        find_cap(1'b0, nl, i);
        chk({tag, " left"}, cap_word[i], exp_slot(a, wide, sf));
      end
      begin
        int nr, i;
        send(1'b1, b); wait_ready(1'b1); nr = n_cap;
        find_cap(1'b1, nr, i);
        chk({tag, " right"}, cap_word[i], exp_slot(b, wide, sf));
      end
    join
  endtask

  task automatic t_underrun();
    int n0, i, j;
    @(negedge clk); w24 = 1'b1; sgn = 1'b1;
    send(1'b0, 24'h8000F0); wait_ready(1'b0); n0 = n_cap;
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 cleared", {31'd0, und}, 0);
    find_cap(1'b0, n0, i);
    chk("R9 fed word", cap_word[i], 32'h8000F0FF);
    find_cap(1'b0, i + 1, j);
    chk("R9 repeated word", cap_word[j], 32'h8000F0FF);
    chk("R9 flag set", {31'd0, und}, 1);
    repeat (40) @(negedge clk);
    chk("R9 flag sticky", {31'd0, und}, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 flag cleared", {31'd0, und}, 0);
  endtask

  task automatic t_stream();
    logic dl = 0, dr = 0;
    fork
      begin
        for (int k = 0; k < 4; k++) begin
          send(1'b0, 24'h100000 + 24'(k)); wait_ready(1'b0);
          if (k == 0) dl = 1;
        end
      end
      begin
        for (int k = 0; k < 4; k++) begin
          send(1'b1, 24'h200000 + 24'(k)); wait_ready(1'b1);
          if (k == 0) dr = 1;
        end
      end
      begin
        wait (dl && dr);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
      end
    join
    chk("R8 R9 no underrun while streaming", {31'd0, und}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(negedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_first_slot();
    t_pair("R5 R6 wide zero", 24'h123456, 24'hF00F0F, 1'b1, 1'b0);
    t_pair("R7 wide sign", 24'h800001, 24'h7FFFFE, 1'b1, 1'b1);
    t_pair("R5 R6 narrow zero", 24'h5A8001, 24'hC37FFF, 1'b0, 1'b0);
    t_pair("R7 narrow sign", 24'hAB8001, 24'h00C0DE, 1'b0, 1'b1);
    t_underrun();
    t_stream();
    chk("R2 line changes only at falling bclk", edge_bad, 0);
    chk("R3 32 periods per ws level", ws_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule